// File: doc/BRIEF.md
# MDIO Management Master Controller

This block is the station-management master for Ethernet PHYs. It turns writes on a small 32-bit register interface into IEEE 802.3 management frames. It drives the management clock (MDC) and the bidirectional data line (MDIO) as a separate output, output-enable and input. A mode bit chooses between Clause 22 framing and Clause 45 framing.

In Clause 45 mode, an access takes two frames. Software first writes the target register number to the address register, which sends an address frame. It then writes the data register, which sends a write frame, or sets the read trigger in the control register, which sends a read frame. In Clause 22 mode, the register number travels in the device field of the control register, and writing the address register sends nothing.

Every frame is 64 MDC periods long. It starts with a 32-bit preamble of ones. The block drives MDIO only on falling MDC edges. During a read it releases the line from the first turnaround bit to the end of the frame. If the PHY does not pull the second turnaround bit low, the block reports a read error and returns all ones.

Top module: `mdio_master`

## Requirements
- R1: After reset the status word (offset 0) reads 0x0102_0008. That is: busy (bit 0) = 0, read error (bit 1) = 0, Clause 45 mode (bit 2) = 0, sample-on-rise (bit 3) = 1, and divider (bits 24:16) = 258. The data word (offset 3) reads 0, with its busy flag (bit 31) clear.
- R2: In Clause 22 mode, writing the data word (offset 3, bits 15:0) sends, MSB first, the following bits: 32 ones, start 01, opcode 01, port (control bits 9:5), register (control bits 4:0), turnaround 10, and the 16-bit value.
- R3: MDC stays low while idle. During a frame MDC has a half period of divider+1 system clocks, and MDIO changes only when MDC falls.
- R4: In Clause 45 mode, writing the address word (offset 2) sends a frame with start 00, opcode 00, port, device, turnaround 10 and the 16-bit address. In Clause 22 mode the same write only stores the value: no MDC edge occurs and busy stays 0.
- R5: Writing the control word with bit 15 set starts a read frame, using the port and device fields written in that same word. The opcode is 10 in Clause 22 mode and 11 in Clause 45 mode. A Clause 45 data write uses start 00 and opcode 01.
- R6: Status bit 0 is set from the launching write until the frame ends, for every frame kind. Data bit 31 is set only for write and read frames, never for address frames.
- R7: In a read frame the master releases MDIO for the last 18 bits. The 16 bits the PHY returns, MSB first, then read back in data bits 15:0.
- R8: If MDIO is high on the second turnaround bit of a read, the data word reads 0xFFFF and status bit 1 is set. Bit 1 stays set through later good reads, and is cleared only by writing the status word with bit 1 = 1.
- R9: Status bit 3 selects when read bits are sampled. When it is 1, bits are sampled on the rising MDC edge. When it is 0, they are sampled on the falling edge that ends the bit. With a PHY that keeps to the standard timing, both settings return the same data.
- R10: While status bit 0 is set, writes to the control, address and data words are ignored. They change no stored field and start no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Word offset: 0 status, 1 control, 2 address, 3 data |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the word selected by reg_addr |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable (1 = master drives) |
| mdio_i | input | 1 | MDIO line as seen at the pad |

## Verification
The assertions rely on three conditions:
- The divider is not rewritten while a frame is running. Otherwise the MDC half period would change mid-frame.
- The MDIO line is resolved outside the block with a pull-up, so an undriven line reads 1.
- No second launch write arrives while busy, apart from the deliberate case in R10.

The bench meets these conditions as follows:
- It polls status bit 0 before every reconfiguration or new launch.
- Its PHY responder drives MDIO only between the second turnaround bit and the last falling edge of a read frame.
- It makes the overlapping writes only in the directed test for R10, and then waits for the frame in flight to end.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
// Package: shared frame constants, frame kinds and the frame builder.
// Assumes a fixed 64-bit management frame with a 32-bit preamble.
package mdio_pkg;

    typedef enum logic [1:0] {
        FK_ADDR  = 2'd0,
        FK_WRITE = 2'd1,
        FK_READ  = 2'd2
    } frame_kind_e;

    localparam logic [1:0] OFS_STAT = 2'd0;
    localparam logic [1:0] OFS_CTRL = 2'd1;
    localparam logic [1:0] OFS_ADDR = 2'd2;
    localparam logic [1:0] OFS_DATA = 2'd3;

    localparam int          FRAME_BITS = 64;
    localparam int          IDX_W      = $clog2(FRAME_BITS);
    localparam logic [IDX_W-1:0] IDX_TA1   = IDX_W'(46);
    localparam logic [IDX_W-1:0] IDX_TA2   = IDX_W'(47);
    localparam logic [IDX_W-1:0] IDX_DATA0 = IDX_W'(48);
    localparam logic [IDX_W-1:0] IDX_LAST  = IDX_W'(FRAME_BITS - 1);

    // Assemble the bit sequence of one frame, MSB sent first.
    function automatic logic [FRAME_BITS-1:0] build_frame(
        input logic        c45,
        input frame_kind_e kind,
        input logic [4:0]  prt,
        input logic [4:0]  dev,
        input logic [15:0] val
    );
        logic [1:0] st;
        logic [1:0] op;
        st = c45 ? 2'b00 : 2'b01;
        case (kind)
            FK_ADDR:  op = 2'b00;
            FK_WRITE: op = 2'b01;
            default:  op = c45 ? 2'b11 : 2'b10;
        endcase
        return {32'hFFFF_FFFF, st, op, prt, dev, 2'b10, val};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
// Module: MDC generator. While run is high, MDC toggles every div+1
// system clocks, starting low. The tick outputs mark the system-clock
// edge at which MDC rises or falls. Assumes div is stable while run is high.
module mdio_clkgen #(
    parameter int DIV_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             mdc,
    output logic             rise_tick,
    output logic             fall_tick
);
    logic [DIV_W-1:0] cnt;
    logic             wrap;

    assign wrap      = run && (cnt == div);
    assign rise_tick = wrap && !mdc;
    assign fall_tick = wrap && mdc;

    // Half-period counter and MDC toggle; parked low when not running.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/mdio_frame_engine.sv
`timescale 1ns/1ps
// Module: frame shifter. Loads a 64-bit frame on start, shifts one bit on
// each MDC fall, and releases MDIO from the first turnaround bit of a read.
// Read bits are sampled on MDC rise or fall, as chosen by sample_rise.
// done pulses one cycle after the last fall, with read results settled.
module mdio_frame_engine
    import mdio_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic                  is_read,
    input  logic                  sample_rise,
    input  logic                  rise_tick,
    input  logic                  fall_tick,
    input  logic                  mdio_i,
    output logic                  active,
    output logic                  mdio_o,
    output logic                  mdio_oe,
    output logic                  done,
    output logic [15:0]           rd_data,
    output logic                  rd_err
);
    logic [IDX_W-1:0]      bitidx;
    logic [FRAME_BITS-1:0] shreg;
    logic                  rd_q;
    logic                  samp;

    assign samp    = sample_rise ? rise_tick : fall_tick;
    assign mdio_o  = shreg[FRAME_BITS-1];
    assign mdio_oe = active && !(rd_q && (bitidx >= IDX_TA1));

    // Frame sequencing, shifting and read-bit capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            bitidx  <= '0;
            shreg   <= '0;
            rd_q    <= 1'b0;
            done    <= 1'b0;
            rd_data <= '0;
            rd_err  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start && !active) begin
                active <= 1'b1;
                bitidx <= '0;
                shreg  <= frame;
                rd_q   <= is_read;
                rd_err <= 1'b0;
            end else if (active) begin
                if (samp && rd_q) begin
                    if (bitidx == IDX_TA2)
                        rd_err <= mdio_i;
                    else if (bitidx >= IDX_DATA0)
                        rd_data <= {rd_data[14:0], mdio_i};
                end
                if (fall_tick) begin
                    if (bitidx == IDX_LAST) begin
                        active <= 1'b0;
                        done   <= 1'b1;
                    end else begin
                        bitidx <= bitidx + IDX_W'(1);
                        shreg  <= {shreg[FRAME_BITS-2:0], 1'b0};
                    end
                end
            end
        end
    end
endmodule

// File: rtl/mdio_regs.sv
`timescale 1ns/1ps
// Module: register file and launch logic. Decodes the four words,
// builds the frame on a launching write, and keeps the busy flags,
// the sticky read error and the returned data.
// Assumes the divider is only rewritten while idle and DIV_W <= 15.
module mdio_regs
    import mdio_pkg::*;
#(
    parameter int               DIV_W   = 9,
    parameter logic [DIV_W-1:0] DIV_RST = DIV_W'(258)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            wr_addr,
    input  logic [31:0]           wdata,
    output logic [31:0]           rdata,
    input  logic                  eng_done,
    input  logic [15:0]           eng_rd_data,
    input  logic                  eng_rd_err,
    output logic                  start,
    output logic [FRAME_BITS-1:0] frame,
    output logic                  is_read,
    output logic                  sample_rise,
    output logic [DIV_W-1:0]      div,
    output logic                  busy,
    output logic                  dbusy,
    output logic                  rd_err,
    output logic [15:0]           data_q
);
    localparam int DIV_LSB = 16;

    logic        c45_q;
    logic [4:0]  port_q;
    logic [4:0]  dev_q;
    logic [15:0] addr_q;
    frame_kind_e kind_q;
    frame_kind_e kind_c;
    logic        open_wr;
    logic        go_ctrl;
    logic        go_addr;
    logic        go_data;
    logic        unused_wdata;

    assign open_wr      = wr_en && !busy;
    assign go_ctrl      = open_wr && (wr_addr == OFS_CTRL) && wdata[15];
    assign go_addr      = open_wr && (wr_addr == OFS_ADDR) && c45_q;
    assign go_data      = open_wr && (wr_addr == OFS_DATA);
    assign is_read      = (kind_q == FK_READ);
    assign unused_wdata = ^wdata[31:DIV_LSB+DIV_W];

    // Pick the frame kind a launching write asks for.
    always_comb begin
        if (go_ctrl)      kind_c = FK_READ;
        else if (go_addr) kind_c = FK_ADDR;
        else              kind_c = FK_WRITE;
    end

    // Register state, frame launch and completion update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c45_q       <= 1'b0;
            sample_rise <= 1'b1;
            div         <= DIV_RST;
            rd_err      <= 1'b0;
            port_q      <= '0;
            dev_q       <= '0;
            addr_q      <= '0;
            data_q      <= '0;
            busy        <= 1'b0;
            dbusy       <= 1'b0;
            kind_q      <= FK_WRITE;
            start       <= 1'b0;
            frame       <= '0;
        end else begin
            start <= 1'b0;
            if (wr_en && (wr_addr == OFS_STAT)) begin
                c45_q       <= wdata[2];
                sample_rise <= wdata[3];
                div         <= wdata[DIV_LSB +: DIV_W];
                if (wdata[1])
                    rd_err <= 1'b0;
            end
            if (open_wr && (wr_addr == OFS_CTRL)) begin
                port_q <= wdata[9:5];
                dev_q  <= wdata[4:0];
            end
            if (open_wr && (wr_addr == OFS_ADDR))
                addr_q <= wdata[15:0];
            if (go_data)
                data_q <= wdata[15:0];
            if (go_ctrl || go_addr || go_data) begin
                busy   <= 1'b1;
                dbusy  <= !go_addr;
                start  <= 1'b1;
                kind_q <= kind_c;
                frame  <= build_frame(c45_q, kind_c,
                                      go_ctrl ? wdata[9:5] : port_q,
                                      go_ctrl ? wdata[4:0] : dev_q,
                                      wdata[15:0]);
            end
            if (eng_done) begin
                busy  <= 1'b0;
                dbusy <= 1'b0;
                if (kind_q == FK_READ) begin
                    data_q <= eng_rd_err ? 16'hFFFF : eng_rd_data;
                    if (eng_rd_err)
                        rd_err <= 1'b1;
                end
            end
        end
    end

    // Read multiplexer over the four words.
    always_comb begin
        rdata = '0;
        case (wr_addr)
            OFS_STAT: begin
                rdata[0]                 = busy;
                rdata[1]                 = rd_err;
                rdata[2]                 = c45_q;
                rdata[3]                 = sample_rise;
                rdata[DIV_LSB +: DIV_W]  = div;
            end
            OFS_CTRL: rdata[9:0]  = {port_q, dev_q};
            OFS_ADDR: rdata[15:0] = addr_q;
            default: begin
                rdata[15:0] = data_q;
                rdata[31]   = dbusy;
            end
        endcase
    end
endmodule

// File: rtl/mdio_master.sv
`timescale 1ns/1ps
// Module: top of the MDIO management master. Joins the register file,
// the MDC generator and the frame engine. MDIO is split into output,
// enable and input; the pad and pull-up live outside this block.
module mdio_master
    import mdio_pkg::*;
#(
    parameter int               DIV_W   = 9,
    parameter logic [DIV_W-1:0] DIV_RST = DIV_W'(258)
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        mdc,
    output logic        mdio_o,
    output logic        mdio_oe,
    input  logic        mdio_i
);
    logic                  start;
    logic [FRAME_BITS-1:0] frame;
    logic                  is_read;
    logic                  sample_rise;
    logic [DIV_W-1:0]      div;
    logic                  busy;
    logic                  dbusy;
    logic                  rd_err;
    logic [15:0]           data_q;
    logic                  eng_active;
    logic                  eng_done;
    logic [15:0]           eng_rd_data;
    logic                  eng_rd_err;
    logic                  rise_tick;
    logic                  fall_tick;

    mdio_regs #(.DIV_W(DIV_W), .DIV_RST(DIV_RST)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(reg_wr), .wr_addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
        .eng_done(eng_done), .eng_rd_data(eng_rd_data), .eng_rd_err(eng_rd_err),
        .start(start), .frame(frame), .is_read(is_read),
        .sample_rise(sample_rise), .div(div),
        .busy(busy), .dbusy(dbusy), .rd_err(rd_err), .data_q(data_q)
    );

    mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
        .clk(clk), .rst_n(rst_n), .run(eng_active), .div(div),
        .mdc(mdc), .rise_tick(rise_tick), .fall_tick(fall_tick)
    );

    mdio_frame_engine u_eng (
        .clk(clk), .rst_n(rst_n),
        .start(start), .frame(frame), .is_read(is_read),
        .sample_rise(sample_rise), .rise_tick(rise_tick), .fall_tick(fall_tick),
        .mdio_i(mdio_i), .active(eng_active),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .done(eng_done),
        .rd_data(eng_rd_data), .rd_err(eng_rd_err)
    );
endmodule

// File: rtl/mdio_master_chk.sv
`timescale 1ns/1ps
// Module: protocol checker bound to mdio_master. Assumes the divider is
// not rewritten during a frame and that MDIO is externally pulled up.
module mdio_master_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mdc,
    input logic        mdio_o,
    input logic        mdio_oe,
    input logic        busy,
    input logic        dbusy,
    input logic        rd_err,
    input logic [15:0] data_q,
    input logic        eng_active,
    input logic        eng_done
);
    // R6: the data busy flag never stands without the status busy flag
    a_r6_dbusy_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        dbusy |-> busy);

    // R6: frame completion always drops busy
    a_r6_done_clears_busy: assert property (@(posedge clk) disable iff (!rst_n)
        eng_done |=> !busy);

    // R3: MDC is parked low outside a frame
    a_r3_mdc_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_active |-> !mdc);

    // R3: MDIO output only moves with a falling MDC
    a_r3_mdio_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        mdc |-> $stable(mdio_o));

    // R7: the master never drives MDIO outside a busy period
    a_r7_drive_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mdio_oe |-> busy);

    // R8: a fresh read error comes with all-ones data
    a_r8_err_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_err) |-> (data_q == 16'hFFFF));
endmodule

bind mdio_master mdio_master_chk u_chk (
    .clk(clk), .rst_n(rst_n), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
    .busy(busy), .dbusy(dbusy), .rd_err(rd_err), .data_q(data_q),
    .eng_active(eng_active), .eng_done(eng_done)
);

// File: tb/tb_mdio_master.sv
`timescale 1ns/1ps
module tb_mdio_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        mdc, mdio_o, mdio_oe, mdio_i;

    int n_chk = 0;
    int n_fail = 0;
    bit reported = 0;

    // PHY responder state
    logic        phy_oe = 1'b0;
    logic        phy_o = 1'b1;
    logic        phy_read = 1'b0;
    logic        phy_present = 1'b1;
    logic [15:0] phy_val = '0;
    logic [5:0]  bitcnt = '0;
    logic [63:0] cap = '0;

    assign mdio_i = mdio_oe ? mdio_o : (phy_oe ? phy_o : 1'b1);

    mdio_master dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    always #4 clk = ~clk;

    // PHY capture: every rising MDC samples the line
    always @(posedge mdc) begin
        cap    <= {cap[62:0], mdio_i};
        bitcnt <= bitcnt + 6'd1;
    end

    // PHY drive: turnaround low then data, changed on falling MDC
    always @(negedge mdc) begin
        if (phy_read && phy_present && bitcnt == 6'd47) begin
            phy_oe = 1'b1; phy_o = 1'b0;
        end else if (phy_read && phy_present && bitcnt >= 6'd48) begin
            phy_oe = 1'b1; phy_o = phy_val[63 - int'(bitcnt)];
        end else begin
            phy_oe = 1'b0; phy_o = 1'b1;
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        int n = 0;
        do begin
            rd(2'd0, s);
            n++;
        end while (s[0] && n < 60000);
        if (s[0]) chk("R6 busy never cleared", 64'd1, 64'd0);
    endtask

    function automatic logic [31:0] stat_w(input logic c45, input logic srise,
                                           input logic [8:0] dv, input logic clr);
        return {7'd0, dv, 12'd0, srise, c45, clr, 1'b0};
    endfunction

    function automatic logic [63:0] exp_frame(input logic c45, input logic [1:0] kind,
        input logic [4:0] p, input logic [4:0] dv, input logic [15:0] v);
        logic [1:0] op;
        if (kind == 2'd0) op = 2'b00;
        else if (kind == 2'd1) op = 2'b01;
        else op = c45 ? 2'b11 : 2'b10;
        return {32'hFFFF_FFFF, (c45 ? 2'b00 : 2'b01), op, p, dv, 2'b10, v};
    endfunction

    // vector: {c45, kind(0 addr,1 write,2 read), port, dev, value}
    localparam logic [28:0] VEC [0:5] = '{
        {1'b0, 2'd1, 5'd1,  5'd2,  16'hA5C3},
        {1'b0, 2'd2, 5'd3,  5'd17, 16'h1234},
        {1'b1, 2'd0, 5'd5,  5'd1,  16'h0007},
        {1'b1, 2'd1, 5'd5,  5'd1,  16'hFEDC},
        {1'b1, 2'd2, 5'd31, 5'd30, 16'h8001},
        {1'b0, 2'd2, 5'd0,  5'd31, 16'h0000}
    };

    // Launch one frame of the given kind and wait for it to finish
    task automatic run_frame(input logic c45, input logic [1:0] kind,
        input logic [4:0] p, input logic [4:0] dv, input logic [15:0] v,
        output logic [31:0] st_after_launch, output logic [31:0] dat_after_launch);
        if (kind == 2'd2) begin
            phy_val = v; phy_read = 1'b1;
            wr(2'd1, {16'd0, 1'b1, 5'd0, p, dv});
        end else begin
            wr(2'd1, {22'd0, p, dv});
            wr((kind == 2'd0) ? 2'd2 : 2'd3, {16'd0, v});
        end
        rd(2'd0, st_after_launch);
        rd(2'd3, dat_after_launch);
        wait_idle();
        phy_read = 1'b0;
    endtask

    initial begin : main
        logic [31:0] r, s0, d0;
        logic [5:0]  bc;
        longint      t0, t1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, r); chk("R1 status reset", r, 32'h0102_0008);
        rd(2'd3, r); chk("R1 data reset", r, 32'h0);
        chk("R3 mdc idle low", mdc, 1'b0);

        // R3 MDC period with the reset divider (258 -> 518 clocks)
        wr(2'd1, {22'd0, 5'd4, 5'd4});
        wr(2'd3, 32'h0000_1111);
        @(posedge mdc); t0 = $time;
        @(posedge mdc); t1 = $time;
        chk("R3 mdc period reset divider", (t1 - t0) / 8, 64'd518);
        wait_idle();

        // fast divider for the rest: half period 2 clocks
        wr(2'd0, stat_w(1'b0, 1'b1, 9'd1, 1'b1));
        wr(2'd3, 32'h0000_2222);
        @(posedge mdc); t0 = $time;
        @(posedge mdc); t1 = $time;
        chk("R3 mdc period divider 1", (t1 - t0) / 8, 64'd4);
        wait_idle();

        // Table walk: R2 R4 R5 R6 R7 frames
        foreach (VEC[i]) begin
            logic        c45;
            logic [1:0]  kind;
            logic [4:0]  p, dv;
            logic [15:0] v;
            logic [63:0] e;
            {c45, kind, p, dv, v} = VEC[i];
            wr(2'd0, stat_w(c45, 1'b1, 9'd1, 1'b1));
            run_frame(c45, kind, p, dv, v, s0, d0);
            chk("R6 busy after launch", s0[0], 1'b1);
            chk("R6 data busy per kind", d0[31], (kind != 2'd0));
            e = exp_frame(c45, kind, p, dv, v);
            chk(kind == 2'd2 ? "R5 R7 read frame bits" :
                (c45 ? "R4 R5 c45 frame bits" : "R2 c22 write frame bits"), cap, e);
            if (kind == 2'd2) begin
                rd(2'd3, r); chk("R7 read data", r, {16'd0, v});
            end
        end

        // R4 address write in Clause 22 mode starts nothing
        wr(2'd0, stat_w(1'b0, 1'b1, 9'd1, 1'b1));
        bc = bitcnt;
        wr(2'd2, 32'h0000_1111);
        rd(2'd0, r); chk("R4 c22 addr write no busy", r[0], 1'b0);
        repeat (20) @(negedge clk);
        chk("R4 c22 addr write no mdc", bitcnt, bc);
        rd(2'd2, r); chk("R4 c22 addr stored", r, 32'h0000_1111);

        // R8 absent PHY: all ones and sticky error
        wr(2'd0, stat_w(1'b1, 1'b1, 9'd1, 1'b1));
        phy_present = 1'b0;
        run_frame(1'b1, 2'd2, 5'd7, 5'd3, 16'h5555, s0, d0);
        phy_present = 1'b1;
        rd(2'd3, r); chk("R8 absent PHY data", r, 32'h0000_FFFF);
        chk("R8 absent PHY frame released", cap, {exp_frame(1'b1, 2'd2, 5'd7, 5'd3, 16'h0)} | 64'h3FFFF);
        rd(2'd0, r); chk("R8 error flag set", r[1], 1'b1);
        run_frame(1'b1, 2'd2, 5'd7, 5'd3, 16'h0F0F, s0, d0);
        rd(2'd3, r); chk("R8 good read after error", r, 32'h0000_0F0F);
        rd(2'd0, r); chk("R8 error stays sticky", r[1], 1'b1);
        wr(2'd0, stat_w(1'b1, 1'b1, 9'd1, 1'b1));
        rd(2'd0, r); chk("R8 error cleared by write one", r[1], 1'b0);

        // R9 sample on the falling edge
        wr(2'd0, stat_w(1'b1, 1'b0, 9'd1, 1'b0));
        run_frame(1'b1, 2'd2, 5'd9, 5'd2, 16'hC35A, s0, d0);
        rd(2'd3, r); chk("R9 fall-edge sampling data", r, 32'h0000_C35A);
        rd(2'd0, r); chk("R9 fall-edge no error", r[1], 1'b0);

        // R10 writes while busy are ignored
        wr(2'd0, stat_w(1'b1, 1'b1, 9'd1, 1'b0));
        bc = bitcnt;
        phy_val = 16'h6B2D; phy_read = 1'b1;
        wr(2'd1, {16'd0, 1'b1, 5'd0, 5'd2, 5'd3});
        wr(2'd1, {22'd0, 5'd9, 5'd9});
        wr(2'd3, 32'h0000_BEEF);
        wr(2'd2, 32'h0000_4444);
        wait_idle();
        phy_read = 1'b0;
        repeat (40) @(negedge clk);
        rd(2'd3, r); chk("R10 data write while busy ignored", r, 32'h0000_6B2D);
        rd(2'd1, r); chk("R10 control write while busy ignored", r, {22'd0, 5'd2, 5'd3});
        rd(2'd2, r); chk("R10 address write while busy ignored", r, 32'h0000_1111);
        chk("R10 only one frame sent", bitcnt, bc);

        if (!reported) begin
            reported = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        end
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        if (!reported) begin
            reported = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        end
        $finish;
    end
endmodule